// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial-peripheral-interface master. A host reaches it through a small register bus. Through that bus the host sets a clock divisor and a control word, pushes transmit words into a queue, and pops received words from a second queue. Each queue holds eight entries. A shift engine takes one word at a time from the transmit queue. It clocks the word out on the serial data output and clocks the same number of bits in from the serial data input. It then places the assembled word in the receive queue.

The control word sets the following:
- the word length, from 2 to 16 bits;
- the idle level of the serial clock;
- which clock edge samples the data;
- the bit order;
- an internal loopback path;
- master operation and a global enable;
- whether each queue runs with eight entries or a single entry;
- a soft reset.

An interrupt tells the host that every queued word has left the shifter. Chip select is left to a general-purpose output elsewhere on the chip.

Registers are 32 bits wide and byte-addressed:

| Offset | Register |
|--------|----------|
| 0x00 | Divisor |
| 0x04 | Transmit push |
| 0x08 | Receive pop |
| 0x0C | Control |
| 0x10 | Interrupt enable (bit 2) |

Writes take effect at the clock edge where `reg_wr` is high. Read data appears on `reg_rdata` one cycle after `reg_rd`.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, `sclk`, `mosi` and `irq` are low, and the divisor, control and interrupt-enable registers read zero.
- R2: Reads return what was written. The divisor reads back on bits [15:0]. The control register reads back on bits [12:0]. The interrupt enable reads back on bit 2 only. Every other bit, and any unmapped offset, reads zero.
- R3: While a word shifts, each half period of `sclk` lasts exactly N clock cycles, where N is the divisor. A divisor of 0 counts 65536 cycles.
- R4: Control bits [3:0] hold the word length minus one. A word produces exactly 2×length `sclk` transitions. The received word comes back right-aligned, with all higher bits zero.
- R5: When control bit 4 is 1, both directions shift the most significant bit first. When it is 0, both directions shift the least significant bit first.
- R6: Control bit 6 sets the idle level of `sclk`. When control bit 5 is 0, data is sampled on the first (leading) edge of each bit. When it is 1, data is sampled on the second (trailing) edge. Outgoing data changes on the edge that does not sample.
- R7: When control bit 10 is set, the receive path takes `mosi`, and `miso` has no effect.
- R8: Each queue holds 8 words. A transmit write into a full queue is dropped. A receive read from an empty queue returns 0 and leaves the queue unchanged. When control bit 11 (transmit) or bit 12 (receive) is clear, that queue holds only one word.
- R9: Words shift only while control bit 8 (master) and bit 9 (enable) are both set. Clearing either bit abandons the current word and returns `sclk` to its idle level.
- R10: While control bit 7 is set, both queues are emptied and the shift engine is held idle.
- R11: `irq` is high when interrupt-enable bit 2 is set, the shifter is idle and the transmit queue is empty. Writing 0 to the interrupt-enable register lowers `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Transmit-drained interrupt |

## Verification
The bench uses the default parameters: 16-bit words, an 8-entry queue and a 16-bit divisor. With the 16-bit divisor, the zero-means-65536 wrap can be measured in a single run. The short queue means nine writes are enough to reach the full-queue drop. The widest word and every bit-order and clock-mode pairing can then be exercised against a model of the remote device in the bench.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int BUS_W = 32;
  localparam int CTL_BITS = 13;

  // register offsets (byte addresses)
  localparam logic [4:0] OFS_DIV  = 5'h00;
  localparam logic [4:0] OFS_TX   = 5'h04;
  localparam logic [4:0] OFS_RX   = 5'h08;
  localparam logic [4:0] OFS_CTL  = 5'h0C;
  localparam logic [4:0] OFS_IE   = 5'h10;

  // control word fields
  localparam int F_MSB   = 4;
  localparam int F_CPHA  = 5;
  localparam int F_CPOL  = 6;
  localparam int F_SRST  = 7;
  localparam int F_MST   = 8;
  localparam int F_EN    = 9;
  localparam int F_LOOP  = 10;
  localparam int F_TXQ   = 11;
  localparam int F_RXQ   = 12;
  localparam int F_IEBIT = 2;

  typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_t;
endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       single,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = single ? (cnt_q != '0) : (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_host_baud.sv
module spi_host_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  // divisor 0 wraps to the full 2**DIV_W count
  assign last = div - 1'b1;
  assign tick = run && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_host_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic [$clog2(W)-1:0] wcode,
  input  logic                 cpha,
  input  logic                 cpol,
  input  logic                 msb,
  input  logic                 loop,
  input  logic                 tick,
  input  logic                 tx_valid,
  input  logic [W-1:0]         tx_data,
  output logic                 tx_pop,
  output logic                 rx_push,
  output logic [W-1:0]         rx_data,
  output logic                 busy,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso
);
  localparam int CODE_W = $clog2(W);
  localparam int N_W    = CODE_W + 1;

  eng_state_t      state_q;
  logic [N_W-1:0]  n_q, n_nx, tidx_w;
  logic [CODE_W-1:0] samp_idx, tx_idx;
  logic [W-1:0]    word_q, rx_q;
  logic            sclk_q, mosi_q, push_q;
  logic            tx_ok, last_edge, rx_in;

  function automatic logic [CODE_W-1:0] place(input logic m,
                                               input logic [CODE_W-1:0] wc,
                                               input logic [CODE_W-1:0] idx);
    return m ? (wc - idx) : idx;
  endfunction

  always_comb begin
    n_nx      = n_q + 1'b1;
    samp_idx  = n_q[N_W-1:1];
    tidx_w    = cpha ? (n_q >> 1) : (n_nx >> 1);
    tx_idx    = tidx_w[CODE_W-1:0];
    tx_ok     = (tidx_w <= {1'b0, wcode});
    last_edge = (n_q == {wcode, 1'b1});
    rx_in     = loop ? mosi_q : miso;
    tx_pop    = (state_q == ENG_IDLE) && go && tx_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      n_q     <= '0;
      word_q  <= '0;
      rx_q    <= '0;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      push_q  <= 1'b0;
    end else begin
      push_q <= 1'b0;
      case (state_q)
        ENG_IDLE: begin
          sclk_q <= cpol;
          if (tx_pop) begin
            word_q  <= tx_data;
            rx_q    <= '0;
            n_q     <= '0;
            mosi_q  <= tx_data[place(msb, wcode, '0)];
            state_q <= ENG_RUN;
          end
        end
        default: begin
          if (!go) begin
            state_q <= ENG_IDLE;
            sclk_q  <= cpol;
          end else if (tick) begin
            if (n_q[0] == cpha) rx_q[place(msb, wcode, samp_idx)] <= rx_in;
            n_q    <= n_nx;
            sclk_q <= ~sclk_q;
            if (tx_ok) mosi_q <= word_q[place(msb, wcode, tx_idx)];
            if (last_edge) begin
              state_q <= ENG_IDLE;
              push_q  <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign busy    = (state_q == ENG_RUN);
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign rx_push = push_q;
  assign rx_data = rx_q;
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  localparam int CODE_W = $clog2(DATA_W);
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  logic [DIV_W-1:0]    div_q;
  logic [CTL_BITS-1:0] ctrl_q;
  logic                ie_q, irq_q;
  logic [BUS_W-1:0]    rdata_q;

  logic sel_div, sel_tx, sel_rx, sel_ctl, sel_ie;
  logic srst, go;
  logic tx_empty, tx_full, tx_pop;
  logic rx_empty, rx_full, rx_push, rx_pop;
  logic [DATA_W-1:0] tx_head, rx_head, rx_word;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic eng_busy, baud_tick;

  assign sel_div = (reg_addr == ADDR_W'(OFS_DIV));
  assign sel_tx  = (reg_addr == ADDR_W'(OFS_TX));
  assign sel_rx  = (reg_addr == ADDR_W'(OFS_RX));
  assign sel_ctl = (reg_addr == ADDR_W'(OFS_CTL));
  assign sel_ie  = (reg_addr == ADDR_W'(OFS_IE));

  assign srst   = ctrl_q[F_SRST];
  assign go     = ctrl_q[F_EN] && ctrl_q[F_MST] && !srst;
  assign rx_pop = reg_rd && sel_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      ctrl_q <= '0;
      ie_q   <= 1'b0;
    end else if (reg_wr) begin
      if (sel_div) div_q  <= reg_wdata[DIV_W-1:0];
      if (sel_ctl) ctrl_q <= reg_wdata[CTL_BITS-1:0];
      if (sel_ie)  ie_q   <= reg_wdata[F_IEBIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= '0;
      if (sel_div) rdata_q[DIV_W-1:0]    <= div_q;
      if (sel_ctl) rdata_q[CTL_BITS-1:0] <= ctrl_q;
      if (sel_ie)  rdata_q[F_IEBIT]      <= ie_q;
      if (sel_rx && !rx_empty) rdata_q[DATA_W-1:0] <= rx_head;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ie_q && !eng_busy && tx_empty;
  end

  spi_host_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(srst), .single(!ctrl_q[F_TXQ]),
    .push(reg_wr && sel_tx), .wdata(reg_wdata[DATA_W-1:0]),
    .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full),
    .count(tx_cnt));

  spi_host_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(srst), .single(!ctrl_q[F_RXQ]),
    .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full),
    .count(rx_cnt));

  spi_host_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .run(eng_busy && go), .div(div_q),
    .tick(baud_tick));

  spi_host_engine #(.W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .go(go), .wcode(ctrl_q[CODE_W-1:0]),
    .cpha(ctrl_q[F_CPHA]), .cpol(ctrl_q[F_CPOL]), .msb(ctrl_q[F_MSB]),
    .loop(ctrl_q[F_LOOP]), .tick(baud_tick),
    .tx_valid(!tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_word), .busy(eng_busy),
    .sclk(sclk), .mosi(mosi), .miso(miso));

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk #(
  parameter int DEPTH = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   sclk,
  input logic                   cpol,
  input logic                   busy,
  input logic                   tick,
  input logic                   srst,
  input logic                   ie_on,
  input logic                   tx_empty,
  input logic                   irq,
  input logic [$clog2(DEPTH):0] tx_cnt,
  input logic [$clog2(DEPTH):0] rx_cnt
);
  localparam int CW = $clog2(DEPTH) + 1;

  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!busy) |-> sclk == $past(cpol));

  p_edge_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && sclk != $past(sclk)) |-> $past(tick));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));

  p_flush_r10: assert property (@(posedge clk) disable iff (rst)
    $past(srst) |-> (tx_cnt == '0 && rx_cnt == '0 && !busy));

  p_irq_cause_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ie_on) && $past(!busy) && $past(tx_empty)));
endmodule

bind spi_host_ctrl spi_host_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .cpol(ctrl_q[spi_host_pkg::F_CPOL]),
  .busy(eng_busy), .tick(baud_tick), .srst(srst), .ie_on(ie_q),
  .tx_empty(tx_empty), .irq(irq), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt));

// File: tb/sim_spi_host_ctrl.sv
module sim_spi_host_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] C_MSB = 32'h10, C_CPHA = 32'h20, C_CPOL = 32'h40,
    C_SRST = 32'h80, C_MST = 32'h100, C_EN = 32'h200, C_LOOP = 32'h400,
    C_TXQ = 32'h800, C_RXQ = 32'h1000;
  localparam logic [31:0] C_RUN = C_MST | C_EN | C_TXQ | C_RXQ;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, mosi, irq;
  logic miso = 1'b0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_host_ctrl u0 (.clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  // wait n cycles, counting sclk transitions
  task automatic idle_count(input int n, output int toggles);
    logic prev;
    prev = sclk; toggles = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (sclk !== prev) toggles++;
      prev = sclk;
    end
  endtask

  function automatic int bpos(input logic m, input int w, input int i);
    return m ? (w - 1 - i) : i;
  endfunction

  // remote device model: drives miso, captures mosi over one word
  task automatic remote(input logic cpha, input logic cpol, input logic m,
                        input int w, input logic [15:0] stx, output logic [15:0] srx);
    int nout, nin;
    nout = 0; nin = 0; srx = '0;
    for (int e = 0; e < 2*w; e++) begin
      @(sclk); #1;
      if (sclk != cpol) begin
        if (!cpha) begin srx[bpos(m, w, nin)] = mosi; nin++; end
        else begin miso = stx[bpos(m, w, nout)]; nout++; end
      end else begin
        if (!cpha) begin nout++; if (nout < w) miso = stx[bpos(m, w, nout)]; end
        else begin srx[bpos(m, w, nin)] = mosi; nin++; end
      end
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 sclk", {31'b0, sclk}, 0);
    chk("R1 mosi", {31'b0, mosi}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(5'h00, d); chk("R1 div", d, 0);
    rd(5'h0C, d); chk("R1 ctrl", d, 0);
    rd(5'h10, d); chk("R1 ie", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(5'h00, 32'hABCD1234); rd(5'h00, d); chk("R2 div", d, 32'h1234);
    wr(5'h0C, 32'hFFFF5F7F); rd(5'h0C, d); chk("R2 ctrl", d, 32'h1F7F);
    wr(5'h0C, 0);
    wr(5'h10, 32'hFFFFFFFF); rd(5'h10, d); chk("R2 ie", d, 32'h4);
    wr(5'h10, 0);
    rd(5'h14, d); chk("R2 unmapped", d, 0);
  endtask

  task automatic t_loop16;
    logic [31:0] d;
    int tg;
    wr(5'h00, 2);
    wr(5'h0C, C_RUN | C_LOOP | C_MSB | 32'hF);
    miso = 1'b1;  // must be ignored in loopback (R7)
    wr(5'h04, 32'hFFFFA5C3);
    wr(5'h04, 32'h00001234);
    idle_count(2*(32*2+4), tg);
    chk("R4 sclk transitions 2 words x16", tg, 64);
    rd(5'h08, d); chk("R7 R4 loopback word0", d, 32'hA5C3);
    rd(5'h08, d); chk("R7 R4 loopback word1", d, 32'h1234);
    miso = 1'b0;
  endtask

  task automatic t_width5;
    logic [31:0] d;
    int tg;
    wr(5'h0C, C_RUN | C_LOOP | 32'h4);
    wr(5'h04, 32'h3F5);
    idle_count(40, tg);
    chk("R4 transitions 5-bit", tg, 10);
    rd(5'h08, d); chk("R4 R5 5-bit lsb-first right-aligned", d, 32'h15);
  endtask

  task automatic t_mode0;
    logic [31:0] d;
    logic [15:0] srx;
    wr(5'h00, 3);
    wr(5'h0C, C_RUN | C_MSB | 32'h7);
    miso = 1'b1;  // bit 7 of 0x96
    wr(5'h04, 32'h4D);
    remote(1'b0, 1'b0, 1'b1, 8, 16'h96, srx);
    chk("R5 R6 mode0 remote got", {16'b0, srx}, 32'h4D);
    repeat (6) @(posedge clk);
    rd(5'h08, d); chk("R5 R6 mode0 master got", d, 32'h96);
  endtask

  task automatic t_mode3;
    logic [31:0] d;
    logic [15:0] srx;
    wr(5'h0C, C_RUN | C_CPOL | C_CPHA | 32'hB);
    repeat (2) @(posedge clk); #1;
    chk("R6 idle level high", {31'b0, sclk}, 1);
    wr(5'h04, 32'hABC);
    remote(1'b1, 1'b1, 1'b0, 12, 16'h5E1, srx);
    chk("R5 R6 mode3 remote got", {16'b0, srx}, 32'hABC);
    repeat (6) @(posedge clk);
    rd(5'h08, d); chk("R5 R6 mode3 master got", d, 32'h5E1);
    wr(5'h0C, 0);
  endtask

  task automatic t_halfperiod;
    int t0, t1, t2;
    wr(5'h00, 3);
    wr(5'h0C, C_RUN | C_LOOP | 32'h1);
    wr(5'h04, 32'h2);
    @(sclk); t0 = $time;
    @(sclk); t1 = $time;
    @(sclk); t2 = $time;
    chk("R3 half period div3 a", (t1 - t0) / CLK_PERIOD, 3);
    chk("R3 half period div3 b", (t2 - t1) / CLK_PERIOD, 3);
    repeat (10) @(posedge clk);
    begin logic [31:0] d; rd(5'h08, d); end
  endtask

  task automatic t_div0_abort;
    logic [31:0] d;
    int k, tg;
    wr(5'h00, 0);
    wr(5'h0C, C_RUN | C_LOOP | 32'h7);
    wr(5'h04, 32'h55);
    k = 0;
    while (sclk == 1'b0 && k < 70000) begin @(posedge clk); #1; k++; end
    checks++;
    if (k < 65536 || k > 65538) begin
      fails++; $display("FAIL R3 div0 first edge actual=%0d expected=65537", k);
    end
    wr(5'h0C, C_MST | C_TXQ | C_RXQ | C_LOOP | 32'h7);  // enable off
    idle_count(2, tg);
    chk("R9 abort sclk idle", {31'b0, sclk}, 0);
    idle_count(50, tg);
    chk("R9 no shifting when disabled", tg, 0);
    rd(5'h08, d); chk("R9 aborted word not received", d, 0);
    wr(5'h00, 2);
  endtask

  task automatic t_fifo;
    logic [31:0] d;
    int tg;
    wr(5'h0C, C_TXQ | C_RXQ | C_LOOP | C_MSB | 32'h7);
    for (int i = 0; i < 9; i++) wr(5'h04, 32'h11 * (i + 1));
    idle_count(20, tg);
    chk("R9 disabled no clock", tg, 0);
    wr(5'h0C, C_RUN | C_LOOP | C_MSB | 32'h7);
    idle_count(8*36 + 20, tg);
    for (int i = 0; i < 8; i++) begin
      rd(5'h08, d); chk("R8 queued word", d, 32'h11 * (i + 1));
    end
    rd(5'h08, d); chk("R8 full write dropped / empty read zero", d, 0);
    rd(5'h08, d); chk("R8 empty read again zero", d, 0);
  endtask

  task automatic t_single;
    logic [31:0] d;
    int tg;
    wr(5'h0C, C_RXQ | C_LOOP | 32'h7);
    wr(5'h04, 32'h21);
    wr(5'h04, 32'h22);
    wr(5'h0C, C_MST | C_EN | C_RXQ | C_LOOP | 32'h7);
    idle_count(80, tg);
    chk("R8 single entry one word shifted", tg, 16);
    rd(5'h08, d); chk("R8 single entry first kept", d, 32'h21);
    rd(5'h08, d); chk("R8 single entry second dropped", d, 0);
  endtask

  task automatic t_srst;
    logic [31:0] d;
    int tg;
    wr(5'h0C, C_TXQ | C_RXQ | C_LOOP | 32'h7);
    for (int i = 0; i < 3; i++) wr(5'h04, 32'h40 + i);
    wr(5'h0C, C_TXQ | C_RXQ | C_LOOP | C_SRST | 32'h7);
    wr(5'h0C, C_RUN | C_LOOP | 32'h7);
    idle_count(60, tg);
    chk("R10 flushed nothing shifts", tg, 0);
    rd(5'h08, d); chk("R10 rx empty after flush", d, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    int tg;
    wr(5'h0C, C_RUN | C_LOOP | 32'h7);
    wr(5'h04, 32'h6A);
    wr(5'h04, 32'h3C);
    wr(5'h10, 32'h4);
    @(posedge clk); #1;
    chk("R11 irq low while shifting", {31'b0, irq}, 0);
    idle_count(80, tg);
    chk("R11 irq high when drained", {31'b0, irq}, 1);
    wr(5'h10, 0);
    @(posedge clk); #1;
    chk("R11 irq masked", {31'b0, irq}, 0);
    rd(5'h08, d); chk("R11 word0", d, 32'h6A);
    rd(5'h08, d); chk("R11 word1", d, 32'h3C);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_regs();
    t_loop16();
    t_width5();
    t_mode0();
    t_mode3();
    t_halfperiod();
    t_div0_abort();
    t_fifo();
    t_single();
    t_srst();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule